// File: doc/BRIEF.md
# External FIFO Flow Gate with Hold-Off Timeout

This block sits between a bus sequencer and an external FIFO. For each pending transfer it decides whether the transfer may proceed in the current cycle. The decision uses the FIFO's full flag for writes and its empty flag for reads. A separate enable bit turns each kind of sensing on or off.

While a transfer is held off by a flag, the block counts bus clocks. When that count reaches a programmable limit, it raises a sticky error flag that can drive an interrupt. A limit of zero turns the timeout off, so a transfer can wait forever. The stalled transfer keeps waiting after the error is raised. The error flag clears only on a write-one pulse.

Top module: `xfifo_gate`

## Requirements
- R1: A request with `reqWrite`=1, `fullSenseEn`=1 and `fifoFull`=1 holds `xferGo` low in that cycle. `fifoEmpty` has no effect on a write.
- R2: A request with `reqWrite`=0, `emptySenseEn`=1 and `fifoEmpty`=1 holds `xferGo` low in that cycle. `fifoFull` has no effect on a read.
- R3: With the matching sense enable at 0, the flag has no effect and `xferGo` equals `reqValid` in the same cycle.
- R4: With `reqValid`=0, `xferGo` is 0. The hold-off count restarts at zero.
- R5: With a nonzero limit N, `errFlag` is still 0 after the (N-1)th consecutive stalled rising edge. It reads 1 after the Nth.
- R6: The hold-off count clears on any edge where the request proceeds or is absent, so a later stall needs N fresh stalled edges.
- R7: A limit of 0 never raises `errFlag`, however long the stall lasts.
- R8: The limit register resets to 255. It loads `limitIn` on an edge with `limitWe`=1 and uses the new value from the next cycle.
- R9: `errFlag` is sticky and the stalled transfer stays stalled after it rises. An edge with `errClear`=1 clears it, unless a new timeout occurs on that same edge, in which case the flag stays set.
- R10: After reset, `errFlag` is 0 and `xferGo` is 0 with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | External bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Transfer pending |
| reqWrite | input | 1 | 1 = write to FIFO, 0 = read from FIFO |
| fifoFull | input | 1 | External FIFO full flag |
| fifoEmpty | input | 1 | External FIFO empty flag |
| fullSenseEn | input | 1 | Enables stalling writes on full |
| emptySenseEn | input | 1 | Enables stalling reads on empty |
| limitWe | input | 1 | Load strobe for the hold-off limit |
| limitIn | input | 8 | New hold-off limit, 0 = no timeout |
| errClear | input | 1 | Write-one pulse that clears the error |
| xferGo | output | 1 | Transfer may proceed this cycle |
| errFlag | output | 1 | Sticky hold-off timeout status |

## Verification
`xferGo` is combinational, so the bench drives inputs on the falling edge and checks it one time step later in the same cycle. The hold-off count and the error flag are registered. A limit of N is checked just after the falling edge that follows the (N-1)th and then the Nth stalled rising edge: the flag must be low at the first check and high at the second. A limit load, an error clear and a count restart each take effect on the next rising edge, and every check is sampled at the falling edge after that rising edge.

// File: rtl/xfg_pkg.sv
package xfg_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic errSet;
  } ctlStrobes_t;
endpackage

// File: rtl/xfg_ctrl.sv
module xfg_ctrl
  import xfg_pkg::*;
(
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        fifoFull,
  input  logic        fifoEmpty,
  input  logic        fullSenseEn,
  input  logic        emptySenseEn,
  input  logic        limitHit,
  output logic        xferGo,
  output ctlStrobes_t strobes
);
  logic wrBlocked;
  logic rdBlocked;
  logic holdOff;

  always_comb begin
    wrBlocked = reqWrite & fullSenseEn & fifoFull;
    rdBlocked = ~reqWrite & emptySenseEn & fifoEmpty;
    holdOff   = reqValid & (wrBlocked | rdBlocked);
    xferGo    = reqValid & ~holdOff;

    strobes.cntInc = holdOff;
    strobes.cntClr = ~holdOff;
    strobes.errSet = holdOff & limitHit;
  end
endmodule

// File: rtl/xfg_dpath.sv
module xfg_dpath
  import xfg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic             limitWe,
  input  logic [CNT_W-1:0] limitIn,
  input  logic             errClear,
  output logic             limitHit,
  output logic             errFlag
);
  localparam logic [CNT_W-1:0] LIMIT_RST = '1;
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

  logic [CNT_W-1:0] limitQ;
  logic [CNT_W-1:0] holdCnt;
  logic [CNT_W-1:0] cntNext;

  always_comb begin
    cntNext  = holdCnt + CNT_ONE;
    limitHit = (limitQ != '0) && (holdCnt != CNT_MAX) && (cntNext == limitQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) limitQ <= LIMIT_RST;
    else if (limitWe) limitQ <= limitIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdCnt <= '0;
    else if (strobes.cntClr) holdCnt <= '0;
    else if (strobes.cntInc && holdCnt != CNT_MAX) holdCnt <= cntNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errFlag <= 1'b0;
    else if (strobes.errSet) errFlag <= 1'b1;
    else if (errClear) errFlag <= 1'b0;
  end
endmodule

// File: rtl/xfifo_gate.sv
module xfifo_gate
  import xfg_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             fifoFull,
  input  logic             fifoEmpty,
  input  logic             fullSenseEn,
  input  logic             emptySenseEn,
  input  logic             limitWe,
  input  logic [CNT_W-1:0] limitIn,
  input  logic             errClear,
  output logic             xferGo,
  output logic             errFlag
);
  ctlStrobes_t strobes;
  logic        limitHit;

  xfg_ctrl u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .fullSenseEn(fullSenseEn), .emptySenseEn(emptySenseEn),
    .limitHit(limitHit), .xferGo(xferGo), .strobes(strobes)
  );

  xfg_dpath #(.CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .limitWe(limitWe), .limitIn(limitIn), .errClear(errClear),
    .limitHit(limitHit), .errFlag(errFlag)
  );
endmodule

// File: rtl/xfg_chk.sv
module xfg_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqWrite,
  input logic fifoFull,
  input logic fifoEmpty,
  input logic fullSenseEn,
  input logic emptySenseEn,
  input logic errClear,
  input logic xferGo,
  input logic errFlag
);
  // R1
  wr_full_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && fullSenseEn && fifoFull) |-> !xferGo);

  // R2
  rd_empty_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && emptySenseEn && fifoEmpty) |-> !xferGo);

  // R3
  unblocked_go_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !(reqWrite && fullSenseEn && fifoFull)
              && !(!reqWrite && emptySenseEn && fifoEmpty)) |-> xferGo);

  // R4
  idle_no_go_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> !xferGo);

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClear) |=> errFlag);

  // R5
  err_only_on_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!errFlag && !(reqValid && !xferGo)) |=> !errFlag);
endmodule

bind xfifo_gate xfg_chk u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .fullSenseEn(fullSenseEn),
  .emptySenseEn(emptySenseEn), .errClear(errClear), .xferGo(xferGo),
  .errFlag(errFlag)
);

// File: tb/xfifo_gate_test.sv
module xfifo_gate_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 0, reqWrite = 0, fifoFull = 0, fifoEmpty = 0;
  logic fullSenseEn = 0, emptySenseEn = 0, limitWe = 0, errClear = 0;
  logic [7:0] limitIn = 8'd0;
  logic xferGo, errFlag;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  xfifo_gate uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .fullSenseEn(fullSenseEn),
    .emptySenseEn(emptySenseEn), .limitWe(limitWe), .limitIn(limitIn),
    .errClear(errClear), .xferGo(xferGo), .errFlag(errFlag)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one rising edge, then settle at the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic idle();
    reqValid = 0; fifoFull = 0; fifoEmpty = 0; errClear = 0; limitWe = 0;
    #1;
  endtask

  task automatic setLimit(input logic [7:0] v);
    limitIn = v; limitWe = 1; tick(); limitWe = 0;
  endtask

  task automatic clearErr();
    errClear = 1; tick(); errClear = 0; #1;
    chk("R9 clear", errFlag, 1'b0);
  endtask

  task automatic testReset();
    chk("R10 go at reset", xferGo, 1'b0);
    chk("R10 err at reset", errFlag, 1'b0);
  endtask

  task automatic testDefaultLimit();
    // R8 default limit 255
    fullSenseEn = 1; reqValid = 1; reqWrite = 1; fifoFull = 1; #1;
    for (int i = 0; i < 254; i++) tick();
    chk("R8 no err at 254", errFlag, 1'b0);
    tick();
    chk("R8 err at 255", errFlag, 1'b1);
    chk("R9 still stalled", xferGo, 1'b0);
    idle();
    clearErr();
  endtask

  task automatic testGating();
    fullSenseEn = 1; emptySenseEn = 1;
    reqValid = 1; reqWrite = 1; fifoFull = 1; fifoEmpty = 0; #1;
    chk("R1 write full stall", xferGo, 1'b0);
    fifoFull = 0; fifoEmpty = 1; #1;
    chk("R1 write ignores empty", xferGo, 1'b1);
    reqWrite = 0; #1;
    chk("R2 read empty stall", xferGo, 1'b0);
    fifoEmpty = 0; fifoFull = 1; #1;
    chk("R2 read ignores full", xferGo, 1'b1);
    fullSenseEn = 0; emptySenseEn = 0; fifoEmpty = 1; #1;
    chk("R3 read sense off", xferGo, 1'b1);
    reqWrite = 1; #1;
    chk("R3 write sense off", xferGo, 1'b1);
    reqValid = 0; #1;
    chk("R4 no request", xferGo, 1'b0);
    idle();
  endtask

  task automatic testTimeout();
    setLimit(8'd5);
    emptySenseEn = 1; reqValid = 1; reqWrite = 0; fifoEmpty = 1; #1;
    for (int i = 0; i < 4; i++) tick();
    chk("R5 no err at N-1", errFlag, 1'b0);
    tick();
    chk("R5 err at N", errFlag, 1'b1);
    idle();
    clearErr();
  endtask

  task automatic testRestart();
    setLimit(8'd5);
    fullSenseEn = 1; reqValid = 1; reqWrite = 1; fifoFull = 1; #1;
    for (int i = 0; i < 3; i++) tick();
    fifoFull = 0; #1;
    chk("R6 proceeds", xferGo, 1'b1);
    tick();
    fifoFull = 1; #1;
    for (int i = 0; i < 4; i++) tick();
    chk("R6 restarted count", errFlag, 1'b0);
    tick();
    chk("R6 err after fresh N", errFlag, 1'b1);
    idle();
    clearErr();
    // request withdrawal also restarts the count
    reqValid = 1; reqWrite = 1; fifoFull = 1; #1;
    for (int i = 0; i < 3; i++) tick();
    reqValid = 0; tick();
    reqValid = 1; #1;
    for (int i = 0; i < 4; i++) tick();
    chk("R4 withdrawal restarts", errFlag, 1'b0);
    idle();
  endtask

  task automatic testZeroLimit();
    setLimit(8'd0);
    fullSenseEn = 1; reqValid = 1; reqWrite = 1; fifoFull = 1; #1;
    for (int i = 0; i < 300; i++) tick();
    chk("R7 no err with zero limit", errFlag, 1'b0);
    chk("R7 still stalled", xferGo, 1'b0);
    idle();
  endtask

  task automatic testSetBeatsClear();
    setLimit(8'd1);
    fullSenseEn = 1; reqValid = 1; reqWrite = 1; fifoFull = 1; #1;
    tick();
    chk("R5 err at limit 1", errFlag, 1'b1);
    fifoFull = 0; tick();
    fifoFull = 1; errClear = 1; #1;
    tick();
    chk("R9 set beats clear", errFlag, 1'b1);
    idle();
    clearErr();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    testReset();
    @(negedge clk); rstN = 1; #1;
    testReset();
    testDefaultLimit();
    testGating();
    testTimeout();
    testRestart();
    testZeroLimit();
    testSetBeatsClear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule